// File: doc/BRIEF.md
# Selection Timeout Timer

This block times how long a bus controller waits for a target to answer a selection or reselection. The input clock goes through a two-stage prescaler: a fixed divider of `BASE_DIV` cycles followed by a programmable clock-conversion factor. Together they produce one time unit. An 8-bit timeout value sets how many time units the wait may last. A register value of zero stands for 256 units.

The controller pulses `sel_start` when a selection begins and `sel_stop` when the target responds. If neither a stop nor a restart arrives before the unit count runs out, the block drops `running` and emits a one-cycle `tmo_evt` pulse. The surrounding logic feeds this pulse into its disconnect/timeout interrupt cause.

The timeout value is written through `tmo_wr`/`tmo_wdata`. The conversion factor arrives on `ccf` and is sampled when the timer starts. Any value below 2 is raised to 2.

Top module: `sel_timeout_timer`

## Requirements
- R1: After reset, `running` and `tmo_evt` are 0 and the stored timeout value is 0, which means 256 units.
- R2: One time unit lasts `BASE_DIV` × factor clock cycles. With a stored value N (1..255), `tmo_evt` is high after the clock edge that lies N units after the edge that sampled `sel_start`.
- R3: On expiry, `tmo_evt` is high for exactly one cycle, and `running` falls on the same edge.
- R4: A stored value of 0 gives a timeout of 2^`UNIT_W` (256) units.
- R5: A conversion factor below 2 (that is, 0 or 1) behaves exactly as a factor of 2.
- R6: A `sel_stop` pulse during a run ends it: `running` falls on the next edge and no `tmo_evt` follows.
- R7: A `sel_stop` in the same cycle as the final unit tick wins, so no `tmo_evt` is produced.
- R8: A `sel_start` while running reloads both prescaler stages and the unit counter, so the timeout is measured from the latest start. A `sel_start` takes priority over a `sel_stop` in the same cycle.
- R9: The timeout value and the factor are captured at start. Writes to the value and changes of `ccf` during a run do not alter the current run. A write in the same cycle as `sel_start` is used by that start.
- R10: `running` is high from the edge that samples `sel_start` until expiry or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_wr | input | 1 | Write strobe for the timeout value |
| tmo_wdata | input | UNIT_W | Timeout value in units (0 = 256) |
| ccf | input | CCF_W | Clock-conversion factor (values below 2 act as 2) |
| sel_start | input | 1 | Selection begins: (re)start timing |
| sel_stop | input | 1 | Target responded: stop timing |
| running | output | 1 | Timer is counting |
| tmo_evt | output | 1 | One-cycle timeout/disconnect event |

## Verification
The bench builds the block with `BASE_DIV` = 5, `CCF_W` = 4 and `UNIT_W` = 8. With these values one unit is only 10 to 75 cycles, so a full 256-unit run with the zero register value finishes within a few thousand cycles. It also keeps the exact expiry edge, a stop on that edge, a restart partway through a run, and the factor floor for 0 and 1 within easy reach. Changing only the base divider does not change the counting structure that the checks exercise.

// File: rtl/sel_timeout_timer.sv
module sel_timeout_timer #(
  parameter int BASE_DIV = 7682,
  parameter int CCF_W    = 4,
  parameter int UNIT_W   = 8,
  parameter int CCF_MIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_wr,
  input  logic [UNIT_W-1:0] tmo_wdata,
  input  logic [CCF_W-1:0]  ccf,
  input  logic              sel_start,
  input  logic              sel_stop,
  output logic              running,
  output logic              tmo_evt
);

  localparam int BASE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam int CNT_W  = UNIT_W + 1;

  logic [UNIT_W-1:0] tmo_q;
  logic [CCF_W-1:0]  ccf_q;
  logic [BASE_W-1:0] pa;
  logic [CCF_W-1:0]  pb;
  logic [CNT_W-1:0]  units;
  logic              run_q, evt_q;

  logic [UNIT_W-1:0] tmo_use;
  logic [CCF_W-1:0]  ccf_eff;
  logic [CNT_W-1:0]  load_units;
  logic              pa_wrap, pb_wrap, tick, last;

  assign tmo_use    = tmo_wr ? tmo_wdata : tmo_q;
  assign ccf_eff    = (ccf < CCF_W'(CCF_MIN)) ? CCF_W'(CCF_MIN) : ccf;
  assign load_units = (tmo_use == '0) ? CNT_W'(1 << UNIT_W) : {1'b0, tmo_use};
  assign pa_wrap    = (pa == BASE_W'(BASE_DIV - 1));
  assign pb_wrap    = (pb == ccf_q - 1'b1);
  assign tick       = run_q & pa_wrap & pb_wrap;
  assign last       = tick & (units == CNT_W'(1));

  assign running = run_q;
  assign tmo_evt = evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= '0;
    else if (tmo_wr) tmo_q <= tmo_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      evt_q <= 1'b0;
      pa    <= '0;
      pb    <= '0;
      units <= '0;
      ccf_q <= CCF_W'(CCF_MIN);
    end else if (sel_start) begin
      run_q <= 1'b1;
      evt_q <= 1'b0;
      pa    <= '0;
      pb    <= '0;
      units <= load_units;
      ccf_q <= ccf_eff;
    end else if (sel_stop) begin
      run_q <= 1'b0;
      evt_q <= 1'b0;
    end else if (run_q) begin
      pa <= pa_wrap ? '0 : pa + 1'b1;
      if (pa_wrap) pb <= pb_wrap ? '0 : pb + 1'b1;
      if (tick) units <= units - 1'b1;
      if (last) run_q <= 1'b0;
      evt_q <= last;
    end else begin
      evt_q <= 1'b0;
    end
  end

  a_r3_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !tmo_evt);
  a_r3_evt_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> (!running && $past(running)));
  a_r6_stop_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stop && !sel_start) |=> (!running && !tmo_evt));
  a_r8_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |=> (running && !tmo_evt));
  a_r5_ccf_floor: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (ccf_q >= CCF_W'(CCF_MIN)));
  a_r4_units_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (units != '0 && units <= CNT_W'(1 << UNIT_W)));
  a_r10_idle_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sel_start) |=> !tmo_evt);

endmodule

// File: tb/sel_timeout_timer_bench.sv
module sel_timeout_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 5;

  logic clk = 0, rst_n = 0;
  logic tmo_wr = 0, sel_start = 0, sel_stop = 0;
  logic [7:0] tmo_wdata = '0;
  logic [3:0] ccf = 4'd2;
  logic running, tmo_evt;

  int cyc = 0, compared = 0, mismatched = 0;
  int exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sel_timeout_timer #(.BASE_DIV(BASE), .CCF_W(4), .UNIT_W(8), .CCF_MIN(2)) u_sel_timeout_timer (
    .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata), .ccf(ccf),
    .sel_start(sel_start), .sel_stop(sel_stop), .running(running), .tmo_evt(tmo_evt));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tmo_evt) begin
      if (exp_q.size() == 0) check("R6/R7 unexpected event", cyc, -1);
      else begin
        check("R2 expiry cycle", cyc, exp_q.pop_front());
        check("R3 running falls with event", running, 0);
      end
    end
  end

  task automatic launch(input int t, input int c, input bit expect_evt);
    int ce = (c < 2) ? 2 : c;
    int n = (t == 0) ? 256 : t;
    @(negedge clk); tmo_wr = 1; tmo_wdata = t[7:0];
    @(negedge clk); tmo_wr = 0; ccf = c[3:0]; sel_start = 1;
    if (expect_evt) exp_q.push_back(cyc + 1 + n * BASE * ce);
    @(negedge clk); sel_start = 0;
    check("R10 running after start", running, 1);
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_stop();
    @(negedge clk); sel_stop = 1;
    @(negedge clk); sel_stop = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 running at reset", running, 0);
    check("R1 event at reset", tmo_evt, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: stored value 0 at reset -> 256 units on a start without a write
    sel_start = 1; ccf = 4'd2; exp_q.push_back(cyc + 1 + 256 * BASE * 2);
    @(negedge clk); sel_start = 0;
    wait_done();
    launch(3, 2, 1); wait_done();          // R2
    launch(1, 5, 1); wait_done();          // R2
    launch(7, 15, 1); wait_done();         // R2
    launch(0, 3, 1); wait_done();          // R4
    launch(2, 0, 1); wait_done();          // R5
    launch(2, 1, 1); wait_done();          // R5
    // R6: stop partway through
    launch(3, 2, 0);
    repeat (4) @(negedge clk);
    pulse_stop();
    check("R6 running after stop", running, 0);
    repeat (40) @(negedge clk);
    // R7: stop on the expiry edge (T = 10, start edge at c+1, expiry edge c+11)
    launch(1, 2, 0);                       // now at cyc = c+1
    repeat (8) @(negedge clk);             // cyc = c+9
    @(negedge clk); sel_stop = 1;          // cyc = c+10, applies to edge c+11
    @(negedge clk); sel_stop = 0;
    check("R7 running after stop at expiry", running, 0);
    repeat (20) @(negedge clk);
    // R8: restart reloads
    launch(2, 2, 0);
    repeat (7) @(negedge clk);
    launch(2, 2, 1); wait_done();
    // R9: changes during run ignored
    launch(2, 3, 1);
    @(negedge clk); tmo_wr = 1; tmo_wdata = 8'd9; ccf = 4'd0;
    @(negedge clk); tmo_wr = 0;
    wait_done();
    // R9: stored 9 applies to next start without a write
    @(negedge clk); ccf = 4'd2; sel_start = 1; exp_q.push_back(cyc + 1 + 9 * BASE * 2);
    @(negedge clk); sel_start = 0;
    wait_done();
    check("R9 queue drained", exp_q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule